// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Status and Interrupt Registers

This block is the register front end of a two-channel bus-master disk controller. Each channel has a command byte whose lowest bit starts and stops its DMA engine. Each channel also has a status byte. The status byte collects interrupt and error events from the engine, shows whether the engine is still moving data, carries two software flags for drive DMA capability, and reports whether the channel is disabled. A shared mode byte shows a second, independent copy of each channel's interrupt and holds the per-channel interrupt block bits and one write-only burst-select bit.

The engines signal interrupt and error events as single-cycle pulses. Each interrupt pulse sets two latches for its channel: the interrupt bit in that channel's status byte, and a separate latch visible in its own latch byte and mirrored in the mode byte. Software clears each latch by writing a one to it. A channel raises the combined interrupt line only while both of its latches are set and its block bit is clear. Register reads are combinational from the byte offset. Writes take effect at the next clock edge.

Top module: `dma_irq_regs`

## Requirements
- R1: After reset, every stored bit is zero: all readable bytes show only their live inputs, `dma_run` is 0, `line_read_burst` is 0 and `irq` is 0.
- R2: The command byte of each channel (offset 0x00 for channel 0, 0x08 for channel 1) stores all 8 written bits and reads them back; its bit 0 drives `dma_run` of that channel from the cycle after the write.
- R3: In a status byte (0x02 channel 0, 0x0A channel 1), bit 2 is set by an interrupt pulse and bit 1 by an error pulse; writing 1 to either bit clears only that bit, and writing 0 leaves it unchanged.
- R4: When an event pulse arrives in the same cycle as a write-one that would clear the same latch, the latch stays set.
- R5: Status bits 6:5 are stored from every write (bit 5 drive 0, bit 6 drive 1). Bit 0 shows `ch_active`, bit 7 shows `ch_disabled`, and bits 4:3 always read 0.
- R6: `clean_done` of a channel is 1 exactly when that channel's status bits [2:0] read 3'b100.
- R7: The mode byte (0x01) shows the channel 0 second latch in bit 2 and the channel 1 second latch in bit 3, read-only. Bits 4 and 5 are stored block bits for channel 0 and channel 1. Bits 7:6 and 0 read 0.
- R8: Mode bit 1 is write-only: each mode write stores it and drives `line_read_burst` from the next cycle, and it always reads as 0.
- R9: The second latch of channel 0 is bit 1 of byte 0x10, and that of channel 1 is bit 4 of byte 0x17. Each is set by its channel's interrupt pulse and cleared by writing 1 to that bit, independently of the status interrupt bit. All other bits of these bytes read 0.
- R10: `irq` is 1 exactly when some channel has its second latch set, its status interrupt bit set and its block bit clear. It falls in the cycle after a write that clears either latch of the last such channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 5 | Byte offset for read and write |
| reg_wr | input | 1 | Write strobe, one byte per cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data at `reg_addr`, combinational |
| ch_intr_pulse | input | 2 | One-cycle interrupt event per channel |
| ch_err_pulse | input | 2 | One-cycle error event per channel |
| ch_active | input | 2 | Engine still transferring, per channel |
| ch_disabled | input | 2 | Channel disabled, per channel |
| dma_run | output | 2 | Start/stop control per channel |
| line_read_burst | output | 1 | Line-read burst select |
| clean_done | output | 2 | Clean-finish indication per channel |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that all inputs are synchronous to `clk`, and that an event pulse means one set request per cycle, whatever its length. They also assume that a write strobe carries a valid offset and data in the same cycle. The stimulus changes every input only just after a rising edge. It raises each pulse for single cycles. It also lines writes up deliberately with pulses on the same latch, so the set-over-clear priority is exercised in both status and second-latch bytes. A reference model in the bench tracks every latch and is compared with all outputs on every cycle, for whatever offset is being read.

// File: rtl/dma_irq_regs.sv
module dma_irq_regs #(
  parameter int AW = 5,
  parameter logic [AW-1:0] A_CMD0 = 'h00,
  parameter logic [AW-1:0] A_MODE = 'h01,
  parameter logic [AW-1:0] A_ST0  = 'h02,
  parameter logic [AW-1:0] A_CMD1 = 'h08,
  parameter logic [AW-1:0] A_ST1  = 'h0A,
  parameter logic [AW-1:0] A_LAT0 = 'h10,
  parameter logic [AW-1:0] A_LAT1 = 'h17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic [1:0]    ch_intr_pulse,
  input  logic [1:0]    ch_err_pulse,
  input  logic [1:0]    ch_active,
  input  logic [1:0]    ch_disabled,
  output logic [1:0]    dma_run,
  output logic          line_read_burst,
  output logic [1:0]    clean_done,
  output logic          irq
);

  logic [1:0][7:0] cmd_q;
  logic [1:0][1:0] dcap_q;
  logic [1:0]      st_intr, st_err, lat, blk;
  logic            lr_q;

  logic [1:0] we_cmd, we_st, lat_clr;
  logic       we_mode;

  assign we_cmd  = {reg_wr && reg_addr == A_CMD1, reg_wr && reg_addr == A_CMD0};
  assign we_st   = {reg_wr && reg_addr == A_ST1,  reg_wr && reg_addr == A_ST0};
  assign we_mode = reg_wr && reg_addr == A_MODE;
  assign lat_clr = {reg_wr && reg_addr == A_LAT1 && reg_wdata[4],
                    reg_wr && reg_addr == A_LAT0 && reg_wdata[1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      dcap_q  <= '0;
      st_intr <= '0;
      st_err  <= '0;
      lat     <= '0;
      blk     <= '0;
      lr_q    <= 1'b0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (we_cmd[c]) cmd_q[c] <= reg_wdata;
        if (we_st[c])  dcap_q[c] <= reg_wdata[6:5];
        if (ch_intr_pulse[c])               st_intr[c] <= 1'b1;
        else if (we_st[c] && reg_wdata[2])  st_intr[c] <= 1'b0;
        if (ch_err_pulse[c])                st_err[c] <= 1'b1;
        else if (we_st[c] && reg_wdata[1])  st_err[c] <= 1'b0;
        if (ch_intr_pulse[c])               lat[c] <= 1'b1;
        else if (lat_clr[c])                lat[c] <= 1'b0;
      end
      if (we_mode) begin
        blk  <= reg_wdata[5:4];
        lr_q <= reg_wdata[1];
      end
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr)
      A_CMD0: reg_rdata = cmd_q[0];
      A_CMD1: reg_rdata = cmd_q[1];
      A_ST0:  reg_rdata = {ch_disabled[0], dcap_q[0], 2'b00, st_intr[0], st_err[0], ch_active[0]};
      A_ST1:  reg_rdata = {ch_disabled[1], dcap_q[1], 2'b00, st_intr[1], st_err[1], ch_active[1]};
      A_MODE: reg_rdata = {2'b00, blk, lat, 2'b00};
      A_LAT0: reg_rdata = {6'b0, lat[0], 1'b0};
      A_LAT1: reg_rdata = {3'b0, lat[1], 4'b0};
      default: reg_rdata = 8'h00;
    endcase
  end

  assign dma_run         = {cmd_q[1][0], cmd_q[0][0]};
  assign line_read_burst = lr_q;
  assign clean_done      = st_intr & ~st_err & ~ch_active;
  assign irq             = |(lat & st_intr & ~blk);

endmodule

module dma_irq_regs_chk #(
  parameter int AW = 5,
  parameter logic [AW-1:0] A_CMD0 = 'h00,
  parameter logic [AW-1:0] A_MODE = 'h01,
  parameter logic [AW-1:0] A_ST0  = 'h02
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] reg_addr,
  input logic          reg_wr,
  input logic [7:0]    reg_wdata,
  input logic [7:0]    reg_rdata,
  input logic [1:0]    ch_intr_pulse,
  input logic [1:0]    ch_active,
  input logic [1:0]    dma_run,
  input logic          line_read_burst,
  input logic [1:0]    clean_done,
  input logic          irq,
  input logic [1:0]    st_intr,
  input logic [1:0]    lat
);

  p_run_follows_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == A_CMD0 |=> dma_run[0] == $past(reg_wdata[0]));

  p_run_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_CMD0) |=> $stable(dma_run[0]));

  p_intr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == A_ST0 && reg_wdata[2] && !ch_intr_pulse[0] |=> !st_intr[0]);

  p_pulse_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ch_intr_pulse[0] |=> st_intr[0] && lat[0]);

  p_clean_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clean_done[0] |-> !ch_active[0]);

  p_burst_wo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == A_MODE |-> !reg_rdata[1]);

  p_burst_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == A_MODE |=> line_read_burst == $past(reg_wdata[1]));

  p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|ch_intr_pulse) || $past(reg_wr));

endmodule

bind dma_irq_regs dma_irq_regs_chk #(.AW(AW), .A_CMD0(A_CMD0), .A_MODE(A_MODE), .A_ST0(A_ST0)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .ch_intr_pulse(ch_intr_pulse), .ch_active(ch_active),
  .dma_run(dma_run), .line_read_burst(line_read_burst), .clean_done(clean_done),
  .irq(irq), .st_intr(st_intr), .lat(lat)
);

// File: tb/sim_dma_irq_regs.sv
`timescale 1ns/1ps
module sim_dma_irq_regs;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [4:0] reg_addr = 0;
  logic       reg_wr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic [1:0] ch_intr_pulse = 0, ch_err_pulse = 0, ch_active = 0, ch_disabled = 0;
  logic [1:0] dma_run, clean_done;
  logic       line_read_burst, irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dma_irq_regs u0 (.*);

  // behavioural reference model
  int m_cmd[2], m_intr[2], m_err[2], m_dcap[2], m_lat[2], m_blk[2];
  int m_lr;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_cmd[c] = 0; m_intr[c] = 0; m_err[c] = 0; m_dcap[c] = 0; m_lat[c] = 0; m_blk[c] = 0;
      end
      m_lr = 0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        int st_a, cmd_a, lat_a, lat_b;
        st_a  = (c == 0) ? 2 : 10;
        cmd_a = (c == 0) ? 0 : 8;
        lat_a = (c == 0) ? 16 : 23;
        lat_b = (c == 0) ? 1 : 4;
        if (reg_wr && reg_addr == cmd_a) m_cmd[c] = reg_wdata;
        if (reg_wr && reg_addr == st_a) m_dcap[c] = (reg_wdata >> 5) & 3;
        if (ch_intr_pulse[c]) m_intr[c] = 1;
        else if (reg_wr && reg_addr == st_a && reg_wdata[2]) m_intr[c] = 0;
        if (ch_err_pulse[c]) m_err[c] = 1;
        else if (reg_wr && reg_addr == st_a && reg_wdata[1]) m_err[c] = 0;
        if (ch_intr_pulse[c]) m_lat[c] = 1;
        else if (reg_wr && reg_addr == lat_a && reg_wdata[lat_b]) m_lat[c] = 0;
      end
      if (reg_wr && reg_addr == 1) begin
        m_blk[0] = reg_wdata[4]; m_blk[1] = reg_wdata[5]; m_lr = reg_wdata[1];
      end
    end
  end

  function automatic int mread(int a);
    case (a)
      0:  return m_cmd[0];
      8:  return m_cmd[1];
      2:  return ch_disabled[0]*128 + m_dcap[0]*32 + m_intr[0]*4 + m_err[0]*2 + ch_active[0];
      10: return ch_disabled[1]*128 + m_dcap[1]*32 + m_intr[1]*4 + m_err[1]*2 + ch_active[1];
      1:  return m_blk[1]*32 + m_blk[0]*16 + m_lat[1]*8 + m_lat[0]*4;
      16: return m_lat[0]*2;
      23: return m_lat[1]*16;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      0, 8: return "R2";
      2, 10: return "R5";
      1: return "R7";
      16, 23: return "R9";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int eirq;
      eirq = 0;
      for (int c = 0; c < 2; c++)
        if (m_lat[c] && m_intr[c] && !m_blk[c]) eirq = 1;
      chk(tag_of(reg_addr), reg_rdata, mread(reg_addr));
      chk("R10", irq, eirq);
      chk("R2", dma_run, (m_cmd[1] & 1) * 2 + (m_cmd[0] & 1));
      chk("R8", line_read_burst, m_lr);
      for (int c = 0; c < 2; c++)
        chk("R6", clean_done[c], (m_intr[c] && !m_err[c] && !ch_active[c]) ? 1 : 0);
    end
  end

  task automatic drive(input logic [4:0] a, input logic w, input logic [7:0] d,
                       input logic [1:0] ip, input logic [1:0] ep);
    @(posedge clk); #1;
    reg_addr = a; reg_wr = w; reg_wdata = d; ch_intr_pulse = ip; ch_err_pulse = ep;
  endtask

  task automatic rd(input logic [4:0] a, input int exp, input string tag);
    drive(a, 0, 0, 0, 0);
    @(negedge clk); #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    drive(a, 1, d, 0, 0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd(5'h02, 8'h00, "R1");
    rd(5'h01, 8'h00, "R1");
    chk("R1", irq, 0);
    chk("R1", dma_run, 0);
    // R2 command byte
    wr(5'h00, 8'hA5);
    rd(5'h00, 8'hA5, "R2");
    chk("R2", dma_run, 2'b01);
    wr(5'h00, 8'hA4);
    rd(5'h00, 8'hA4, "R2");
    chk("R2", dma_run, 2'b00);
    // R3 / R6 interrupt with engine active, then idle
    @(posedge clk); #1 ch_active = 2'b01;
    drive(5'h02, 0, 0, 2'b01, 0);
    rd(5'h02, 8'h05, "R3");
    chk("R6", clean_done[0], 0);
    @(posedge clk); #1 ch_active = 2'b00;
    rd(5'h02, 8'h04, "R6");
    chk("R6", clean_done[0], 1);
    rd(5'h10, 8'h02, "R9");
    rd(5'h01, 8'h04, "R7");
    chk("R10", irq, 1);
    // error then clear only error
    drive(5'h02, 0, 0, 0, 2'b01);
    rd(5'h02, 8'h06, "R3");
    chk("R6", clean_done[0], 0);
    wr(5'h02, 8'h02);
    rd(5'h02, 8'h04, "R3");
    // R7 block, R8 write-only
    wr(5'h01, 8'h10);
    rd(5'h01, 8'h14, "R7");
    chk("R10", irq, 0);
    wr(5'h01, 8'h02);
    rd(5'h01, 8'h04, "R8");
    chk("R8", line_read_burst, 1);
    chk("R10", irq, 1);
    // R9 independence: clear status bit, second latch stays
    wr(5'h02, 8'h04);
    rd(5'h02, 8'h00, "R3");
    chk("R10", irq, 0);
    rd(5'h10, 8'h02, "R9");
    // R10 clear second latch drops irq
    drive(5'h00, 0, 0, 2'b01, 0);
    rd(5'h02, 8'h04, "R3");
    chk("R10", irq, 1);
    wr(5'h10, 8'h02);
    rd(5'h10, 8'h00, "R9");
    chk("R10", irq, 0);
    // R4 pulse and clear in the same cycle
    drive(5'h02, 1, 8'h04, 2'b01, 0);
    rd(5'h02, 8'h04, "R4");
    drive(5'h10, 1, 8'h02, 2'b01, 0);
    rd(5'h10, 8'h02, "R4");
    // R5 capability flags, disabled flag, reserved bits
    wr(5'h02, 8'h60);
    rd(5'h02, 8'h64, "R5");
    @(posedge clk); #1 ch_disabled = 2'b01;
    rd(5'h02, 8'hE4, "R5");
    wr(5'h02, 8'h18);
    rd(5'h02, 8'h84, "R5");
    @(posedge clk); #1 ch_disabled = 2'b00;
    // channel 1
    drive(5'h17, 0, 0, 2'b10, 0);
    rd(5'h17, 8'h10, "R9");
    rd(5'h01, 8'h0C, "R7");
    chk("R10", irq, 1);
    wr(5'h01, 8'h30);
    rd(5'h01, 8'h3C, "R7");
    chk("R10", irq, 0);
    wr(5'h08, 8'h01);
    rd(5'h08, 8'h01, "R2");
    chk("R2", dma_run, 2'b10);
    // mixed random traffic, compared every cycle by the model
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] a;
      int k;
      k = $urandom_range(0, 7);
      case (k)
        0: a = 5'h00; 1: a = 5'h01; 2: a = 5'h02; 3: a = 5'h08;
        4: a = 5'h0A; 5: a = 5'h10; 6: a = 5'h17; default: a = 5'($urandom);
      endcase
      drive(a, ($urandom_range(0, 2) == 0), 8'($urandom),
            {($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0)},
            {($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0)});
      if ($urandom_range(0, 15) == 0) ch_active = 2'($urandom);
      if ($urandom_range(0, 31) == 0) ch_disabled = 2'($urandom);
    end
    drive(5'h00, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    #1;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule